// File: doc/BRIEF.md
# Two-Bank DRAM Command Timing Guard

This block sits between a memory controller and a synchronous DRAM with two internal banks. It watches a decoded command stream and keeps track of each bank: whether it is open, which row it holds, and how many clock cycles have passed since the events that timing rules depend on. In the cycle a command is presented, the block either grants it or rejects it. A rejected command leaves the tracked state untouched. In the following cycle a violation flag pulses with a 3-bit code that names the broken rule.

Timing limits are loaded as nanosecond values together with the clock period. At load time each limit becomes a cycle count by ceiling division. A load is taken only while neither bank is open. The block also watches how long each bank has been open. When a bank is held open past the maximum open time, the block reports an overrun once for that activation, without waiting for a command.

Top module: `dram_timing_guard`

## Requirements
- R1: After reset both banks are closed, `openRows` is zero, `violation` is low, and the precharge and activate-spacing timers count as already expired.
- R2: Command encoding on `cmdOp`: 0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 burst stop; 6 and 7 behave as nop. An activate to an open bank, or a read or write to a closed bank, is rejected with code 7. A granted activate opens the bank and records `cmdRow` in `openRows[bank*ROW_W +: ROW_W]`. Nop, burst stop and a precharge of a closed bank are always granted and change nothing.
- R3: A read or write issued k cycles after its bank's activate is rejected with code 1 while k is below the row-to-column cycle count.
- R4: An activate to bank b issued k cycles after a granted activate to the other bank is rejected with code 2 while k is below the bank-to-bank activate count.
- R5: A precharge to an open bank issued k cycles after its activate is rejected with code 3 while k is below the minimum open-time count.
- R6: When a bank has been open for more cycles than the maximum open-time count, the block raises code 4 once per activation. The pulse appears in the cycle after the first cycle in which the limit is exceeded. A command violation in the same cycle takes precedence, and the overrun is reported afterwards.
- R7: An activate to a closed bank issued k cycles after its granted precharge is rejected with code 5 while k is below the row-precharge count. A granted precharge closes the bank.
- R8: After a write at cycle w, a precharge to that bank at cycle p is rejected with code 6 when p-w < BURST_LEN-1 + write-recovery count. The rule is waived when `cmdMask` is high with the precharge. Code 3 takes precedence over code 6.
- R9: Each limit is converted to ceil(ns / period) cycles. A period of 0 is treated as 1.
- R10: `cfgLoad` is taken only when both banks are closed. Otherwise it is ignored and the previous counts stay in force.
- R11: All cycle counters saturate at 2^CNT_W-1 instead of wrapping. Converted counts above that value are clamped to it.
- R12: `cmdGrant` is combinational and only high with `cmdValid`. A rejected command changes no state. `violation` and `vioCode` are registered and pulse for one cycle after the offending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Load the nanosecond limits below |
| cfgPeriodNs | input | NS_W | Clock period in ns |
| cfgRcdNs | input | NS_W | Activate to read/write delay |
| cfgRrdNs | input | NS_W | Activate to activate, different banks |
| cfgRasMinNs | input | NS_W | Minimum open time |
| cfgRasMaxNs | input | NS_W | Maximum open time |
| cfgRpNs | input | NS_W | Row precharge time |
| cfgWrNs | input | NS_W | Write recovery after last data |
| cmdValid | input | 1 | Command present |
| cmdOp | input | 3 | Command code |
| cmdBank | input | 1 | Target bank |
| cmdRow | input | ROW_W | Row for activate |
| cmdMask | input | 1 | Remaining write data blocked (with precharge) |
| cmdGrant | output | 1 | Command accepted this cycle |
| violation | output | 1 | Rule broken, one-cycle pulse |
| vioCode | output | 3 | Code of the broken rule |
| bankActive | output | 2 | Open flag per bank |
| openRows | output | 2*ROW_W | Row held by each bank |

## Verification
The bench probes each spacing rule at the last rejected cycle and at the first granted cycle. A design that floors instead of rounding up, or that is off by one in its counters, grants a command one cycle early. Other tests check that a rejected activate does not restart the bank-to-bank timer, that a configuration load while a bank is open has no effect, and that the overrun pulse appears exactly once and in the expected cycle. Saturation is tested by waiting until a wrapping precharge counter would land at zero, and by clamping a maximum open time that would otherwise fold to a small count.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_BST = 3'd5
  } cmdOp_e;

  typedef enum logic [2:0] {
    VIO_NONE   = 3'd0,
    VIO_RCD    = 3'd1,
    VIO_RRD    = 3'd2,
    VIO_RASMIN = 3'd3,
    VIO_RASMAX = 3'd4,
    VIO_RP     = 3'd5,
    VIO_WR     = 3'd6,
    VIO_STATE  = 3'd7
  } vioCode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic       doAct;
    logic       doPre;
    logic       doWr;
    logic       bank;
    logic       takeCfg;
    logic [1:0] ovAck;
  } strobe_t;

  // datapath -> control timing status, one bit per bank
  typedef struct packed {
    logic [1:0] active;
    logic [1:0] rcdOk;
    logic [1:0] rasMinOk;
    logic [1:0] rpOk;
    logic [1:0] rrdOk;
    logic [1:0] wrOk;
    logic [1:0] overrun;
  } status_t;

endpackage

// File: rtl/dtg_data.sv
module dtg_data
  import dtg_pkg::*;
#(
  parameter int NS_W          = 16,
  parameter int CNT_W         = 16,
  parameter int ROW_W         = 12,
  parameter int BURST_LEN     = 4,
  parameter int DEF_PERIOD_NS = 10,
  parameter int DEF_RCD_NS    = 20,
  parameter int DEF_RRD_NS    = 20,
  parameter int DEF_RASMIN_NS = 50,
  parameter int DEF_RASMAX_NS = 60000,
  parameter int DEF_RP_NS     = 20,
  parameter int DEF_WR_NS     = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [NS_W-1:0]    cfgPeriodNs,
  input  logic [NS_W-1:0]    cfgRcdNs,
  input  logic [NS_W-1:0]    cfgRrdNs,
  input  logic [NS_W-1:0]    cfgRasMinNs,
  input  logic [NS_W-1:0]    cfgRasMaxNs,
  input  logic [NS_W-1:0]    cfgRpNs,
  input  logic [NS_W-1:0]    cfgWrNs,
  input  logic [ROW_W-1:0]   cmdRow,
  output status_t            st,
  output logic [2*ROW_W-1:0] openRows
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W:0]   WR_EXTRA = (CNT_W+1)'(BURST_LEN - 1);

  function automatic logic [CNT_W-1:0] toCyc(input logic [NS_W-1:0] ns,
                                             input logic [NS_W-1:0] per);
    logic [31:0] p;
    logic [31:0] q;
    p = (per == '0) ? 32'd1 : 32'(per);
    q = (32'(ns) + p - 32'd1) / p;
    return (q > 32'(CNT_MAX)) ? CNT_MAX : q[CNT_W-1:0];
  endfunction

  logic [CNT_W-1:0] rcdCyc, rrdCyc, rasMinCyc, rasMaxCyc, rpCyc, wrCyc;
  logic [CNT_W-1:0] sinceLastAct;
  logic             lastBank;
  logic [CNT_W:0]   wrNeed;

  assign wrNeed = {1'b0, wrCyc} + WR_EXTRA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rcdCyc    <= toCyc(NS_W'(DEF_RCD_NS),    NS_W'(DEF_PERIOD_NS));
      rrdCyc    <= toCyc(NS_W'(DEF_RRD_NS),    NS_W'(DEF_PERIOD_NS));
      rasMinCyc <= toCyc(NS_W'(DEF_RASMIN_NS), NS_W'(DEF_PERIOD_NS));
      rasMaxCyc <= toCyc(NS_W'(DEF_RASMAX_NS), NS_W'(DEF_PERIOD_NS));
      rpCyc     <= toCyc(NS_W'(DEF_RP_NS),     NS_W'(DEF_PERIOD_NS));
      wrCyc     <= toCyc(NS_W'(DEF_WR_NS),     NS_W'(DEF_PERIOD_NS));
    end else if (stb.takeCfg) begin
      rcdCyc    <= toCyc(cfgRcdNs,    cfgPeriodNs);
      rrdCyc    <= toCyc(cfgRrdNs,    cfgPeriodNs);
      rasMinCyc <= toCyc(cfgRasMinNs, cfgPeriodNs);
      rasMaxCyc <= toCyc(cfgRasMaxNs, cfgPeriodNs);
      rpCyc     <= toCyc(cfgRpNs,     cfgPeriodNs);
      wrCyc     <= toCyc(cfgWrNs,     cfgPeriodNs);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceLastAct <= CNT_MAX;
      lastBank     <= 1'b0;
    end else if (stb.doAct) begin
      sinceLastAct <= CNT_W'(1);
      lastBank     <= stb.bank;
    end else if (sinceLastAct != CNT_MAX) begin
      sinceLastAct <= sinceLastAct + CNT_W'(1);
    end
  end

  logic [1:0] activeV, rcdOkV, rasMinOkV, rpOkV, rrdOkV, wrOkV, overrunV;

  for (genvar b = 0; b < 2; b++) begin : gBank
    logic             active, wrPend, ovDone;
    logic [ROW_W-1:0] row;
    logic [CNT_W-1:0] sinceAct, sincePre, sinceWr;
    logic             hitAct, hitPre, hitWr;

    assign hitAct = stb.doAct && (stb.bank == 1'(b));
    assign hitPre = stb.doPre && (stb.bank == 1'(b));
    assign hitWr  = stb.doWr  && (stb.bank == 1'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        active   <= 1'b0;
        row      <= '0;
        sinceAct <= '0;
        sincePre <= CNT_MAX;
        sinceWr  <= CNT_MAX;
        wrPend   <= 1'b0;
        ovDone   <= 1'b0;
      end else begin
        if (hitAct) begin
          active   <= 1'b1;
          row      <= cmdRow;
          sinceAct <= CNT_W'(1);
          wrPend   <= 1'b0;
          ovDone   <= 1'b0;
        end else begin
          if (sinceAct != CNT_MAX) sinceAct <= sinceAct + CNT_W'(1);
          if (stb.ovAck[b]) ovDone <= 1'b1;
        end
        if (hitPre) begin
          active   <= 1'b0;
          sincePre <= CNT_W'(1);
        end else if (sincePre != CNT_MAX) begin
          sincePre <= sincePre + CNT_W'(1);
        end
        if (hitWr) begin
          sinceWr <= CNT_W'(1);
          wrPend  <= 1'b1;
        end else if (sinceWr != CNT_MAX) begin
          sinceWr <= sinceWr + CNT_W'(1);
        end
      end
    end

    assign activeV[b]   = active;
    assign rcdOkV[b]    = sinceAct >= rcdCyc;
    assign rasMinOkV[b] = sinceAct >= rasMinCyc;
    assign rpOkV[b]     = sincePre >= rpCyc;
    assign rrdOkV[b]    = (lastBank == 1'(b)) || (sinceLastAct >= rrdCyc);
    assign wrOkV[b]     = !wrPend || (sinceWr == CNT_MAX) || ({1'b0, sinceWr} >= wrNeed);
    assign overrunV[b]  = active && !ovDone && (sinceAct > rasMaxCyc);
    assign openRows[b*ROW_W +: ROW_W] = row;
  end

  always_comb begin
    st.active   = activeV;
    st.rcdOk    = rcdOkV;
    st.rasMinOk = rasMinOkV;
    st.rpOk     = rpOkV;
    st.rrdOk    = rrdOkV;
    st.wrOk     = wrOkV;
    st.overrun  = overrunV;
  end

endmodule

// File: rtl/dtg_ctrl.sv
module dtg_ctrl
  import dtg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgLoad,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       cmdBank,
  input  logic       cmdMask,
  input  status_t    st,
  output strobe_t    stb,
  output logic       cmdGrant,
  output logic       violation,
  output logic [2:0] vioCode
);

  vioCode_e cmdVio;
  cmdOp_e   op;

  assign op = cmdOp_e'(cmdOp);

  always_comb begin
    cmdGrant    = 1'b0;
    cmdVio      = VIO_NONE;
    stb         = '0;
    stb.bank    = cmdBank;
    stb.takeCfg = cfgLoad && (st.active == 2'b00);
    if (cmdValid) begin
      unique case (op)
        OP_ACT: begin
          if (st.active[cmdBank])      cmdVio = VIO_STATE;
          else if (!st.rpOk[cmdBank])  cmdVio = VIO_RP;
          else if (!st.rrdOk[cmdBank]) cmdVio = VIO_RRD;
          else begin cmdGrant = 1'b1; stb.doAct = 1'b1; end
        end
        OP_RD, OP_WR: begin
          if (!st.active[cmdBank])     cmdVio = VIO_STATE;
          else if (!st.rcdOk[cmdBank]) cmdVio = VIO_RCD;
          else begin cmdGrant = 1'b1; stb.doWr = (op == OP_WR); end
        end
        OP_PRE: begin
          if (!st.active[cmdBank])                    cmdGrant = 1'b1;
          else if (!st.rasMinOk[cmdBank])             cmdVio = VIO_RASMIN;
          else if (!(st.wrOk[cmdBank] || cmdMask))    cmdVio = VIO_WR;
          else begin cmdGrant = 1'b1; stb.doPre = 1'b1; end
        end
        default: cmdGrant = 1'b1;
      endcase
    end
    if (cmdVio == VIO_NONE) begin
      if (st.overrun[0])      stb.ovAck = 2'b01;
      else if (st.overrun[1]) stb.ovAck = 2'b10;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violation <= 1'b0;
      vioCode   <= VIO_NONE;
    end else if (cmdVio != VIO_NONE) begin
      violation <= 1'b1;
      vioCode   <= cmdVio;
    end else if (stb.ovAck != 2'b00) begin
      violation <= 1'b1;
      vioCode   <= VIO_RASMAX;
    end else begin
      violation <= 1'b0;
      vioCode   <= VIO_NONE;
    end
  end

endmodule

// File: rtl/dram_timing_guard.sv
module dram_timing_guard
  import dtg_pkg::*;
#(
  parameter int NS_W          = 16,
  parameter int CNT_W         = 16,
  parameter int ROW_W         = 12,
  parameter int BURST_LEN     = 4,
  parameter int DEF_PERIOD_NS = 10,
  parameter int DEF_RCD_NS    = 20,
  parameter int DEF_RRD_NS    = 20,
  parameter int DEF_RASMIN_NS = 50,
  parameter int DEF_RASMAX_NS = 60000,
  parameter int DEF_RP_NS     = 20,
  parameter int DEF_WR_NS     = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgLoad,
  input  logic [NS_W-1:0]    cfgPeriodNs,
  input  logic [NS_W-1:0]    cfgRcdNs,
  input  logic [NS_W-1:0]    cfgRrdNs,
  input  logic [NS_W-1:0]    cfgRasMinNs,
  input  logic [NS_W-1:0]    cfgRasMaxNs,
  input  logic [NS_W-1:0]    cfgRpNs,
  input  logic [NS_W-1:0]    cfgWrNs,
  input  logic               cmdValid,
  input  logic [2:0]         cmdOp,
  input  logic               cmdBank,
  input  logic [ROW_W-1:0]   cmdRow,
  input  logic               cmdMask,
  output logic               cmdGrant,
  output logic               violation,
  output logic [2:0]         vioCode,
  output logic [1:0]         bankActive,
  output logic [2*ROW_W-1:0] openRows
);

  strobe_t stb;
  status_t st;

  dtg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdMask(cmdMask), .st(st),
    .stb(stb), .cmdGrant(cmdGrant), .violation(violation), .vioCode(vioCode)
  );

  dtg_data #(
    .NS_W(NS_W), .CNT_W(CNT_W), .ROW_W(ROW_W), .BURST_LEN(BURST_LEN),
    .DEF_PERIOD_NS(DEF_PERIOD_NS), .DEF_RCD_NS(DEF_RCD_NS),
    .DEF_RRD_NS(DEF_RRD_NS), .DEF_RASMIN_NS(DEF_RASMIN_NS),
    .DEF_RASMAX_NS(DEF_RASMAX_NS), .DEF_RP_NS(DEF_RP_NS), .DEF_WR_NS(DEF_WR_NS)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cfgPeriodNs(cfgPeriodNs), .cfgRcdNs(cfgRcdNs), .cfgRrdNs(cfgRrdNs),
    .cfgRasMinNs(cfgRasMinNs), .cfgRasMaxNs(cfgRasMaxNs), .cfgRpNs(cfgRpNs),
    .cfgWrNs(cfgWrNs), .cmdRow(cmdRow), .st(st), .openRows(openRows)
  );

  assign bankActive = st.active;

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [2:0] cmdOp,
  input logic       cmdBank,
  input logic       cmdGrant,
  input logic       violation,
  input logic [2:0] vioCode,
  input logic [1:0] bankActive
);

  AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    cmdGrant |-> cmdValid); // R12

  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdGrant) |=> (violation && vioCode != 3'd0 && vioCode != 3'd4)); // R12

  AST_GRANT_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdGrant) |=> (!violation || vioCode == 3'd4)); // R12

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdGrant && cmdOp == 3'd1) |=> bankActive[$past(cmdBank)]); // R2

  AST_ACT_NEEDS_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd1 && bankActive[cmdBank]) |-> !cmdGrant); // R2

  AST_ACCESS_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdOp == 3'd2 || cmdOp == 3'd3) && !bankActive[cmdBank]) |-> !cmdGrant); // R2

  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdGrant && cmdOp == 3'd4) |=> !bankActive[$past(cmdBank)]); // R7

  AST_VIO_CODED: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> vioCode != 3'd0); // R12

endmodule

bind dram_timing_guard dtg_checker uChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .cmdBank(cmdBank), .cmdGrant(cmdGrant), .violation(violation),
  .vioCode(vioCode), .bankActive(bankActive)
);

// File: tb/dram_timing_guard_test.sv
module dram_timing_guard_test;

  localparam int NS_W  = 16;
  localparam int CNT_W = 6;
  localparam int ROW_W = 12;
  localparam int CLK_NS = 20;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               cfgLoad = 1'b0;
  logic [NS_W-1:0]    cfgPeriodNs = '0, cfgRcdNs = '0, cfgRrdNs = '0;
  logic [NS_W-1:0]    cfgRasMinNs = '0, cfgRasMaxNs = '0, cfgRpNs = '0, cfgWrNs = '0;
  logic               cmdValid = 1'b0;
  logic [2:0]         cmdOp = '0;
  logic               cmdBank = 1'b0;
  logic [ROW_W-1:0]   cmdRow = '0;
  logic               cmdMask = 1'b0;
  logic               cmdGrant, violation;
  logic [2:0]         vioCode;
  logic [1:0]         bankActive;
  logic [2*ROW_W-1:0] openRows;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  dram_timing_guard #(.NS_W(NS_W), .CNT_W(CNT_W), .ROW_W(ROW_W), .BURST_LEN(4)) uut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgPeriodNs(cfgPeriodNs),
    .cfgRcdNs(cfgRcdNs), .cfgRrdNs(cfgRrdNs), .cfgRasMinNs(cfgRasMinNs),
    .cfgRasMaxNs(cfgRasMaxNs), .cfgRpNs(cfgRpNs), .cfgWrNs(cfgWrNs),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdRow(cmdRow),
    .cmdMask(cmdMask), .cmdGrant(cmdGrant), .violation(violation),
    .vioCode(vioCode), .bankActive(bankActive), .openRows(openRows)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic nops(input int n);
    repeat (n) @(negedge clk);
  endtask

  // present one command for one cycle; check grant now and the flag next cycle
  task automatic issue(input logic [2:0] op, input logic bank, input int row,
                       input logic mask, input bit expGrant, input int expCode,
                       input string tag);
    cmdValid = 1'b1; cmdOp = op; cmdBank = bank; cmdRow = ROW_W'(row); cmdMask = mask;
    #2;
    check(cmdGrant == expGrant, {tag, " grant"}, int'(cmdGrant), int'(expGrant));
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd0; cmdMask = 1'b0;
    check(int'(violation ? vioCode : 3'd0) == expCode, {tag, " code"},
          int'(violation ? vioCode : 3'd0), expCode);
  endtask

  task automatic loadCfg(input int per, input int rcd, input int rrd, input int rasMin,
                         input int rasMax, input int rp, input int wr);
    cfgPeriodNs = NS_W'(per); cfgRcdNs = NS_W'(rcd); cfgRrdNs = NS_W'(rrd);
    cfgRasMinNs = NS_W'(rasMin); cfgRasMaxNs = NS_W'(rasMax);
    cfgRpNs = NS_W'(rp); cfgWrNs = NS_W'(wr);
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  // period 20: rcd 3, rrd 2, rasMin 5, rasMax 50, rp 2, wr 2
  task automatic loadStd();
    loadCfg(20, 45, 30, 90, 1000, 40, 25);
  endtask

  task automatic closeAll();
    nops(6);
    issue(3'd4, 1'b0, 0, 1'b0, 1'b1, 0, "close b0");
    issue(3'd4, 1'b1, 0, 1'b0, 1'b1, 0, "close b1");
    nops(3);
  endtask

  task automatic t_reset();
    check(bankActive == 2'b00, "R1 banks closed", int'(bankActive), 0);
    check(openRows == '0, "R1 rows zero", int'(openRows), 0);
    check(violation == 1'b0, "R1 no violation", int'(violation), 0);
    issue(3'd1, 1'b1, 9, 1'b0, 1'b1, 0, "R1 act right after reset");
    check(openRows[ROW_W +: ROW_W] == 12'd9, "R2 row b1 recorded",
          int'(openRows[ROW_W +: ROW_W]), 9);
    nops(5);
    issue(3'd4, 1'b1, 0, 1'b0, 1'b1, 0, "R7 close b1");
    nops(3);
  endtask

  task automatic t_spacing();
    issue(3'd1, 1'b0, 5, 1'b0, 1'b1, 0, "R2 act b0");                // c0
    check(bankActive[0] == 1'b1, "R2 b0 open", int'(bankActive[0]), 1);
    check(openRows[ROW_W-1:0] == 12'd5, "R2 row b0", int'(openRows[ROW_W-1:0]), 5);
    nops(1);                                                          // c1
    issue(3'd2, 1'b0, 0, 1'b0, 1'b0, 1, "R3 R9 read at 2 cycles");     // c2
    issue(3'd2, 1'b0, 0, 1'b0, 1'b1, 0, "R3 read at 3 cycles");        // c3
    issue(3'd4, 1'b0, 0, 1'b0, 1'b0, 3, "R5 pre at 4 cycles");         // c4
    issue(3'd4, 1'b0, 0, 1'b0, 1'b1, 0, "R5 pre at 5 cycles");         // c5
    check(bankActive[0] == 1'b0, "R7 b0 closed", int'(bankActive[0]), 0);
    issue(3'd1, 1'b0, 6, 1'b0, 1'b0, 5, "R7 act 1 after pre");         // c6
    issue(3'd1, 1'b0, 6, 1'b0, 1'b1, 0, "R7 act 2 after pre");         // c7
    issue(3'd1, 1'b1, 7, 1'b0, 1'b0, 2, "R4 other bank 1 later");      // c8
    issue(3'd1, 1'b1, 7, 1'b0, 1'b1, 0, "R4 R12 other bank 2 later");  // c9
    issue(3'd1, 1'b0, 8, 1'b0, 1'b0, 7, "R2 act open bank");           // c10
    check(openRows[ROW_W-1:0] == 12'd6, "R12 rejected act keeps row",
          int'(openRows[ROW_W-1:0]), 6);
    issue(3'd5, 1'b0, 0, 1'b0, 1'b1, 0, "R2 burst stop granted");
    closeAll();
  endtask

  task automatic t_writeRecovery();
    issue(3'd1, 1'b0, 1, 1'b0, 1'b1, 0, "R8 act");
    nops(4);
    issue(3'd3, 1'b0, 0, 1'b0, 1'b1, 0, "R8 write");                   // w
    nops(3);
    issue(3'd4, 1'b0, 0, 1'b0, 1'b0, 6, "R8 pre at w+4");
    issue(3'd4, 1'b0, 0, 1'b0, 1'b1, 0, "R8 pre at w+5");
    nops(2);
    issue(3'd1, 1'b0, 2, 1'b0, 1'b1, 0, "R8 reopen");
    nops(4);
    issue(3'd3, 1'b0, 0, 1'b0, 1'b1, 0, "R8 write 2");
    issue(3'd4, 1'b0, 0, 1'b1, 1'b1, 0, "R8 masked pre at w+1");
    issue(3'd2, 1'b1, 0, 1'b0, 1'b0, 7, "R2 read closed bank");
    nops(3);
  endtask

  task automatic t_config();
    issue(3'd1, 1'b0, 3, 1'b0, 1'b1, 0, "R10 act");
    loadCfg(20, 200, 30, 90, 1000, 40, 25);                           // ignored
    nops(5);
    issue(3'd4, 1'b0, 0, 1'b0, 1'b1, 0, "R10 pre");
    nops(2);
    issue(3'd1, 1'b0, 3, 1'b0, 1'b1, 0, "R10 act again");
    nops(2);
    issue(3'd2, 1'b0, 0, 1'b0, 1'b1, 0, "R10 old rcd still in force");
    nops(5);
    issue(3'd4, 1'b0, 0, 1'b0, 1'b1, 0, "R10 pre 2");
    nops(2);
    loadCfg(20, 200, 30, 90, 1000, 40, 25);                           // taken: rcd 10
    issue(3'd1, 1'b0, 3, 1'b0, 1'b1, 0, "R10 act 3");
    nops(2);
    issue(3'd2, 1'b0, 0, 1'b0, 1'b0, 1, "R10 new rcd applied");
    nops(6);
    issue(3'd4, 1'b0, 0, 1'b0, 1'b1, 0, "R10 pre 3");
    nops(2);
    loadCfg(0, 3, 2, 5, 50, 2, 2);                                    // period 0
    issue(3'd1, 1'b0, 3, 1'b0, 1'b1, 0, "R9 act");
    nops(1);
    issue(3'd2, 1'b0, 0, 1'b0, 1'b0, 1, "R9 zero period read at 2");
    issue(3'd2, 1'b0, 0, 1'b0, 1'b1, 0, "R9 zero period read at 3");
    nops(3);
    issue(3'd4, 1'b0, 0, 1'b0, 1'b1, 0, "R9 pre");
    nops(2);
  endtask

  task automatic t_overrun();
    int first = 0;
    int hits = 0;
    loadCfg(20, 45, 30, 90, 200, 40, 25);                             // rasMax 10
    issue(3'd1, 1'b0, 4, 1'b0, 1'b1, 0, "R6 act");
    for (int k = 1; k <= 20; k++) begin
      if (violation && vioCode == 3'd4) begin
        hits++;
        if (first == 0) first = k;
      end
      @(negedge clk);
    end
    check(first == 12, "R6 overrun cycle", first, 12);
    check(hits == 1, "R6 overrun once", hits, 1);
    issue(3'd4, 1'b0, 0, 1'b0, 1'b1, 0, "R6 pre");
    nops(2);
  endtask

  task automatic t_saturate();
    int hits = 0;
    loadCfg(20, 45, 30, 90, 5000, 40, 25);                            // rasMax clamps to 63
    issue(3'd1, 1'b0, 2, 1'b0, 1'b1, 0, "R11 act");
    for (int k = 1; k <= 100; k++) begin
      if (violation) hits++;
      @(negedge clk);
    end
    check(hits == 0, "R11 clamped max open, no overrun", hits, 0);
    issue(3'd4, 1'b0, 0, 1'b0, 1'b1, 0, "R11 pre");                   // c0
    nops(63);
    issue(3'd1, 1'b0, 2, 1'b0, 1'b1, 0, "R11 act at 64, counter held");
    nops(5);
    issue(3'd4, 1'b0, 0, 1'b0, 1'b1, 0, "R11 final pre");
  endtask

  initial begin
    nops(3);
    rstN = 1'b1;
    nops(1);
    t_reset();
    loadStd();
    t_spacing();
    t_writeRecovery();
    t_config();
    loadStd();
    t_overrun();
    t_saturate();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule